// File: doc/BRIEF.md
# Teletext Bit-Slot Timing Generator

This block schedules serial teletext bits onto selected lines of a 625-line raster that is timed by a 27 MHz sample clock. A line of 1728 clocks holds 444 teletext bit periods on average. That rate does not divide the clock evenly, so the block uses bit slots of uneven length. Inside each group of 37 bits, four fixed slots last three clocks and the rest last four. Each group therefore spans exactly 144 clocks.

The surrounding timing logic supplies a line number, a field flag and a horizontal sample count. Configuration inputs select the lines that carry data in each field, gate the whole function on the video standard and a global enable, set how far ahead the data request runs, and choose a test pattern. The block raises a request strobe for the upstream data source. It samples the serial input once at the start of every slot and presents the held bit with a valid flag to a downstream edge-shaping filter.

Top module: `ttx_slot_gen`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `dataReq`, `bitOut` and `bitValid` are 0.
- R2: On an enabled line the window opens at `hCount == WIN_START`. The first serial sample is taken at the rising edge that sees `hCount == WIN_START+1`. `bitValid` is high after every edge from that one through the edge that sees `hCount == WIN_START + WIN_GROUPS*144`, which is exactly `WIN_GROUPS*144` cycles.
- R3: Bit positions inside a group are counted from 1, restarting at 1 when each window opens and after every 37th bit. Positions 10, 19, 28 and 37 last 3 clocks. All other positions last 4 clocks.
- R4: `serIn` is sampled at the first rising edge of each slot, and that value stays on `bitOut` for the whole slot.
- R5: `dataReq` is registered. After the edge that sees horizontal count h on an enabled line, it is 1 exactly when `h + cfgAdvance` lies in `[WIN_START, WIN_START + WIN_GROUPS*144 - 1]`. With `cfgAdvance = 0`, it leads each sample edge by one cycle.
- R6: With `field2 = 0`, bit i of `f1Mask` (i = 0..16) enables line 6+i. No other line of that field is enabled.
- R7: With `field2 = 1`, bit i of `f2Mask` (i = 0..17) enables line 318+i. No other line of that field is enabled.
- R8: No line is enabled unless both `cfgPal = 1` and `cfgTtxEn = 1`.
- R9: With `cfgTestPat = 1`, `serIn` is ignored. The first bit of the window is 1 and later bits alternate 0,1,0,…
- R10: Outside a window `bitValid` and `bitOut` are 0. `dataReq` stays 0 for the whole of a line that is not enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineNum | input | 10 | Current line number, 1-based |
| field2 | input | 1 | 1 while the second field is scanned |
| hCount | input | 11 | Horizontal sample count, 0..1727 |
| cfgPal | input | 1 | 1 when the 625-line standard is selected |
| cfgTtxEn | input | 1 | Global teletext enable |
| cfgTestPat | input | 1 | Replace input data with alternating pattern |
| cfgAdvance | input | 8 | Clocks by which the request is moved earlier |
| f1Mask | input | 17 | Line enables for lines 6..22 of field one |
| f2Mask | input | 18 | Line enables for lines 318..335 of field two |
| serIn | input | 1 | Serial teletext data from the source |
| dataReq | output | 1 | Request strobe to the data source |
| bitOut | output | 1 | Held teletext bit |
| bitValid | output | 1 | High while `bitOut` carries window data |

## Verification
The bench drives a serial stream whose value changes from slot to slot. Any misplaced short slot, or a group counter that fails to restart at 37, shifts every later bit and shows up as a data mismatch. It also counts the valid cycles, and a window one slot too long or too short fails that count. It moves the request with a nonzero and a large advance, because a request computed without the advance, or with the wrong sign, opens at the wrong count. It probes the first and last enabled line of each field, the lines just outside each range, and a first-field line number presented in the second field. A wrong mask offset or a field mix-up would then insert data on a line that should stay dark.

// File: rtl/ttx_slot_pkg.sv
package ttx_slot_pkg;
  localparam int GROUP_BITS  = 37;
  localparam int LONG_LEN    = 4;
  localparam int SHORT_LEN   = 3;
  localparam int SHORT_STEP  = 9;
  localparam int SHORT_COUNT = (GROUP_BITS - 1) / SHORT_STEP;
  localparam int GROUP_CLKS  = GROUP_BITS * LONG_LEN - SHORT_COUNT * (LONG_LEN - SHORT_LEN);

  typedef struct packed {
    logic sample;
    logic idle;
    logic patVal;
  } ttxStrobe_t;
endpackage

// File: rtl/ttx_slot_ctrl.sv
module ttx_slot_ctrl
  import ttx_slot_pkg::*;
#(
  parameter int LW         = 10,
  parameter int HW         = 11,
  parameter int AW         = 8,
  parameter int WIN_START  = 256,
  parameter int WIN_GROUPS = 10,
  parameter int F1_FIRST   = 6,
  parameter int F1_LINES   = 17,
  parameter int F2_FIRST   = 318,
  parameter int F2_LINES   = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LW-1:0]       lineNum,
  input  logic                field2,
  input  logic [HW-1:0]       hCount,
  input  logic                cfgPal,
  input  logic                cfgTtxEn,
  input  logic [AW-1:0]       cfgAdvance,
  input  logic [F1_LINES-1:0] f1Mask,
  input  logic [F2_LINES-1:0] f2Mask,
  output logic                dataReq,
  output ttxStrobe_t          stb
);
  localparam int WIN_CLKS = WIN_GROUPS * GROUP_CLKS;
  localparam int IDXW     = $clog2(GROUP_BITS + 1);
  localparam int GW       = $clog2(WIN_GROUPS) + 1;
  localparam int CW       = $clog2(LONG_LEN);
  localparam int SW       = HW + 1;

  logic            active;
  logic [CW-1:0]   clkCnt;
  logic [IDXW-1:0] bitIdx;
  logic [GW-1:0]   grpCnt;
  logic            patBit;
  logic            f1Hit, f2Hit, lineOk;
  logic            shortSlot, lastClk;
  logic [SW-1:0]   hSum;
  logic            reqHit;

  always_comb begin
    f1Hit = 1'b0;
    for (int i = 0; i < F1_LINES; i++)
      if (lineNum == LW'(F1_FIRST + i) && f1Mask[i]) f1Hit = 1'b1;
    f2Hit = 1'b0;
    for (int i = 0; i < F2_LINES; i++)
      if (lineNum == LW'(F2_FIRST + i) && f2Mask[i]) f2Hit = 1'b1;
  end

  assign lineOk    = cfgPal && cfgTtxEn && (field2 ? f2Hit : f1Hit);
  assign shortSlot = (bitIdx % IDXW'(SHORT_STEP) == IDXW'(1)) && (bitIdx != IDXW'(1));
  assign lastClk   = clkCnt == (shortSlot ? CW'(SHORT_LEN - 1) : CW'(LONG_LEN - 1));
  assign hSum      = {1'b0, hCount} + SW'(cfgAdvance);
  assign reqHit    = (hSum >= SW'(WIN_START)) && (hSum < SW'(WIN_START + WIN_CLKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      clkCnt  <= '0;
      bitIdx  <= IDXW'(1);
      grpCnt  <= '0;
      patBit  <= 1'b0;
      dataReq <= 1'b0;
    end else begin
      dataReq <= lineOk && reqHit;
      if (!active) begin
        if (lineOk && hCount == HW'(WIN_START)) begin
          active <= 1'b1;
          clkCnt <= '0;
          bitIdx <= IDXW'(1);
          grpCnt <= '0;
          patBit <= 1'b1;
        end
      end else if (lastClk) begin
        clkCnt <= '0;
        patBit <= !patBit;
        if (bitIdx == IDXW'(GROUP_BITS)) begin
          bitIdx <= IDXW'(1);
          if (grpCnt == GW'(WIN_GROUPS - 1)) active <= 1'b0;
          else grpCnt <= grpCnt + GW'(1);
        end else begin
          bitIdx <= bitIdx + IDXW'(1);
        end
      end else begin
        clkCnt <= clkCnt + CW'(1);
      end
    end
  end

  assign stb.sample = active && (clkCnt == '0);
  assign stb.idle   = !active;
  assign stb.patVal = patBit;

  // R3
  slot_index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (bitIdx >= IDXW'(1) && bitIdx <= IDXW'(GROUP_BITS)));
  // R3
  slot_min_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |-> ##1 !stb.sample ##1 !stb.sample);
  // R2
  win_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(hCount) == HW'(WIN_START));
endmodule

// File: rtl/ttx_slot_dp.sv
module ttx_slot_dp
  import ttx_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ttxStrobe_t stb,
  input  logic       cfgTestPat,
  input  logic       serIn,
  output logic       bitOut,
  output logic       bitValid
);
  logic srcBit;
  assign srcBit = cfgTestPat ? stb.patVal : serIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
    end else if (stb.sample) begin
      bitOut   <= srcBit;
      bitValid <= 1'b1;
    end else if (stb.idle) begin
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
    end
  end

  // R4
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.sample && !stb.idle) |=> $stable(bitOut));
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.idle |=> (!bitValid && !bitOut));
endmodule

// File: rtl/ttx_slot_gen.sv
module ttx_slot_gen
  import ttx_slot_pkg::*;
#(
  parameter int LW         = 10,
  parameter int HW         = 11,
  parameter int AW         = 8,
  parameter int WIN_START  = 256,
  parameter int WIN_GROUPS = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [LW-1:0] lineNum,
  input  logic          field2,
  input  logic [HW-1:0] hCount,
  input  logic          cfgPal,
  input  logic          cfgTtxEn,
  input  logic          cfgTestPat,
  input  logic [AW-1:0] cfgAdvance,
  input  logic [16:0]   f1Mask,
  input  logic [17:0]   f2Mask,
  input  logic          serIn,
  output logic          dataReq,
  output logic          bitOut,
  output logic          bitValid
);
  ttxStrobe_t stb;

  ttx_slot_ctrl #(
    .LW(LW), .HW(HW), .AW(AW), .WIN_START(WIN_START), .WIN_GROUPS(WIN_GROUPS),
    .F1_FIRST(6), .F1_LINES(17), .F2_FIRST(318), .F2_LINES(18)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lineNum(lineNum), .field2(field2), .hCount(hCount),
    .cfgPal(cfgPal), .cfgTtxEn(cfgTtxEn), .cfgAdvance(cfgAdvance),
    .f1Mask(f1Mask), .f2Mask(f2Mask), .dataReq(dataReq), .stb(stb)
  );

  ttx_slot_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgTestPat(cfgTestPat), .serIn(serIn),
    .bitOut(bitOut), .bitValid(bitValid)
  );
endmodule

// File: tb/tb_ttx_slot_gen.sv
module tb_ttx_slot_gen;
  localparam int S  = 256;
  localparam int WG = 10;
  localparam int WC = WG * 144;

  logic        clk = 0;
  logic        rstN = 0;
  logic [9:0]  lineNum = 0;
  logic        field2 = 0;
  logic [10:0] hCount = 0;
  logic        cfgPal = 1, cfgTtxEn = 1, cfgTestPat = 0;
  logic [7:0]  cfgAdvance = 0;
  logic [16:0] f1Mask = 0;
  logic [17:0] f2Mask = 0;
  logic        serIn = 0;
  logic        dataReq, bitOut, bitValid;

  int nTests = 0;
  int nFail  = 0;

  ttx_slot_gen #(.WIN_START(S), .WIN_GROUPS(WG)) dut (
    .clk(clk), .rstN(rstN), .lineNum(lineNum), .field2(field2), .hCount(hCount),
    .cfgPal(cfgPal), .cfgTtxEn(cfgTtxEn), .cfgTestPat(cfgTestPat),
    .cfgAdvance(cfgAdvance), .f1Mask(f1Mask), .f2Mask(f2Mask), .serIn(serIn),
    .dataReq(dataReq), .bitOut(bitOut), .bitValid(bitValid)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, string what, bit ok, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // global bit index for window offset o (R3 slot lengths)
  function automatic int bitAt(int o);
    int g, r, len;
    g = o / 144;
    r = o % 144;
    for (int j = 1; j <= 37; j++) begin
      len = ((j % 9 == 1) && (j != 1)) ? 3 : 4;
      if (r < len) return g * 37 + j - 1;
      r -= len;
    end
    return -1;
  endfunction

  function automatic bit dataBit(int k);
    return 1'(((k ^ (k >> 2)) ^ (k / 7)) & 1);
  endfunction

  task automatic runLine(int line, bit f2, bit en, string req);
    int badV = 0, badO = 0, badR = 0, nValid = 0;
    int aV = 0, eV = 0, aO = 0, eO = 0, aR = 0, eR = 0;
    bit tp;
    int adv;
    tp  = cfgTestPat;
    adv = int'(cfgAdvance);
    lineNum = 10'(line);
    field2  = f2;
    for (int h = 0; h < 1728; h++) begin
      bit inWin, xV, xO, xR;
      int k;
      hCount = 11'(h);
      k = (h >= S + 1 && h <= S + WC) ? bitAt(h - S - 1) : 0;
      serIn = dataBit(k) ^ (h < S + 1);
      @(negedge clk);
      inWin = en && (h >= S + 1) && (h <= S + WC);
      xV = inWin;
      xO = inWin ? (tp ? (k % 2 == 0) : dataBit(k)) : 1'b0;
      xR = en && (h + adv >= S) && (h + adv < S + WC);
      if (bitValid) nValid++;
      if (bitValid !== xV && badV == 0) begin aV = bitValid; eV = xV; end
      if (bitValid !== xV) badV++;
      if (bitOut !== xO && badO == 0) begin aO = bitOut; eO = xO; end
      if (bitOut !== xO) badO++;
      if (dataReq !== xR && badR == 0) begin aR = dataReq; eR = xR; end
      if (dataReq !== xR) badR++;
    end
    chk(req, $sformatf("line %0d bitValid", line), badV == 0, aV, eV);
    chk(req, $sformatf("line %0d bitOut", line), badO == 0, aO, eO);
    chk(req, $sformatf("line %0d dataReq", line), badR == 0, aR, eR);
    chk(req, $sformatf("line %0d valid cycles", line), nValid == (en ? WC : 0), nValid, en ? WC : 0);
  endtask

  task automatic tReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {dataReq, bitOut, bitValid} == 3'b000, {dataReq, bitOut, bitValid}, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1", "after release", {dataReq, bitOut, bitValid} == 3'b000, {dataReq, bitOut, bitValid}, 0);
  endtask

  task automatic tBasic();
    f1Mask = 17'h00001; cfgAdvance = 0; cfgTestPat = 0;
    runLine(6, 0, 1, "R2 R3 R4 R5 R6");
  endtask

  task automatic tField1Top();
    f1Mask = 17'h10000; cfgAdvance = 8'd37;
    runLine(22, 0, 1, "R5 R6");
  endtask

  task automatic tField2();
    f2Mask = 18'h20001; cfgAdvance = 8'd255;
    runLine(318, 1, 1, "R7 R5");
    runLine(335, 1, 1, "R7");
  endtask

  task automatic tMasked();
    f1Mask = 17'h1FFFD; cfgAdvance = 0;
    runLine(7, 0, 0, "R6 R10");
  endtask

  task automatic tRange();
    f1Mask = '1; f2Mask = '1;
    runLine(5, 0, 0, "R6 R10");
    runLine(23, 0, 0, "R6");
    runLine(317, 1, 0, "R7");
    runLine(10, 1, 0, "R7 field");
    runLine(336, 1, 0, "R7");
  endtask

  task automatic tGate();
    f1Mask = '1;
    cfgPal = 0;
    runLine(12, 0, 0, "R8 pal");
    cfgPal = 1; cfgTtxEn = 0;
    runLine(12, 0, 0, "R8 en");
    cfgTtxEn = 1;
  endtask

  task automatic tTestPat();
    f1Mask = '1; cfgTestPat = 1; cfgAdvance = 8'd3;
    runLine(9, 0, 1, "R9");
    cfgTestPat = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tBasic();
    tField1Top();
    tField2();
    tMasked();
    tRange();
    tGate();
    tTestPat();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule